// File: doc/BRIEF.md
# Chunked I2C Master Transfer Engine

This block is an I2C bus master that carries out one short command at a time. A command moves from one to four data bytes to or from a 7-bit target through a small shared byte buffer. Before a write command, the host pushes the outgoing bytes into the buffer. After a read command, it pops the received bytes from the same buffer. Each command also says how it ends: with a stop that releases the bus, with SCL held low so that the next command continues the same transfer, or with a repeated start so that a read can follow a write without giving up the bus.

The engine drives SCL and SDA as open-drain pull-downs and reads back both lines. It uses this read-back to detect a missing acknowledge, to detect loss of arbitration, and to watch for start and stop conditions so that it can report whether the bus is free. Errors are latched in sticky flags. Each flag clears when a 1 is written to its bit in the clear mask.

Top module: `chunk_i2c_master`

## Requirements
- R1: `cmd_ctrl[5:4]` holds the byte count minus one. A command sends or receives exactly that many data bytes after the address byte, even when the buffer holds more.
- R2: `pending` rises on the clock edge after `cmd_wr` is sampled while it is low, and falls when the command completes. A `cmd_wr` seen while `pending` is high is ignored.
- R3: When chain (`cmd_ctrl[1]`) is set, the command ends with SCL held low and no stop. The next command continues the same transfer with neither a start nor an address byte.
- R4: When repeated-start (`cmd_ctrl[2]`) is set on a command with chain clear, the command ends with a repeated start and then holds SCL and SDA low. The next command sends its address byte with its own direction bit.
- R5: A read (`cmd_ctrl[0]`=1) places the received bytes in the buffer in bus order and raises `buf_ne`. The master acknowledges every byte except the final byte of an unchained command, which it does not acknowledge.
- R6: A missing acknowledge on the address byte or on a written data byte ends the command with a stop and sets `incomplete` and `err`.
- R7: If a write needs its next byte while the buffer is empty, the command ends with a stop and sets `aborted` and `err`.
- R8: If SDA reads low while the master is releasing it for a 1 bit of the address or of write data, `arb_lost` and `err` are set, both lines are released, and `pending` falls.
- R9: `err` is the OR of `arb_lost`, `incomplete` and `aborted`. A pulse on `clr_wr` clears each flag whose mask bit is 1: bit 0 `stop_done`, bit 1 `arb_lost`, bit 2 `incomplete`, bit 3 `aborted`.
- R10: `bus_busy` is set by a start condition seen on the lines and cleared by a stop condition. `stop_done` is set when the master finishes a stop.
- R11: Each SCL high phase lasts 2×`QTR_FAST` clocks when `fast_mode` is 1 and 2×`QTR_STD` clocks otherwise.
- R12: A `flush` pulse empties the byte buffer, and `buf_ne` reads 0 afterwards.
- R13: `sda_oe` changes only while SCL is low, except when the master makes a start, repeated start or stop condition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fast_mode | input | 1 | Selects the short quarter-bit period |
| cmd_wr | input | 1 | Command strobe |
| cmd_ctrl | input | 8 | [0] read, [1] chain, [2] repeated start, [5:4] count-1 |
| dev_addr | input | 7 | Target address |
| wr_push | input | 1 | Push `wr_data` into the buffer |
| wr_data | input | 8 | Byte to push |
| rd_pop | input | 1 | Pop the buffer head |
| rd_data | output | 8 | Buffer head |
| flush | input | 1 | Empty the buffer |
| clr_wr | input | 1 | Clear strobe for the flags |
| clr_mask | input | 4 | Flags to clear, one bit each |
| pending | output | 1 | Command in progress |
| err | output | 1 | Any error flag set |
| buf_ne | output | 1 | Buffer not empty |
| arb_lost | output | 1 | Arbitration lost |
| incomplete | output | 1 | Acknowledge missing |
| aborted | output | 1 | Write ran out of buffered bytes |
| bus_busy | output | 1 | Bus currently owned by some master |
| stop_done | output | 1 | Stop condition completed |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |

## Verification
The assertions take for granted that SCL is pulled low only by this master or by a target that stretches the clock, and that SDA is driven by others only in acknowledge or read-data slots, with one exception: a competing master during arbitration. The stimulus uses a behavioural target that changes SDA only while SCL is low. It uses a competing pull-down exactly once, during an address byte, and that pull-down is released with SCL high so that the bus returns to free through a stop. Buffer pushes, pops and flushes are issued only while no command is pending, so the host never races the engine for the buffer.

// File: rtl/chunk_i2c_master.sv
module chunk_i2c_master #(
  parameter int QTR_STD  = 20,
  parameter int QTR_FAST = 5,
  parameter int CNT_W    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fast_mode,
  input  logic       cmd_wr,
  input  logic [7:0] cmd_ctrl,
  input  logic [6:0] dev_addr,
  input  logic       wr_push,
  input  logic [7:0] wr_data,
  input  logic       rd_pop,
  output logic [7:0] rd_data,
  input  logic       flush,
  input  logic       clr_wr,
  input  logic [3:0] clr_mask,
  output logic       pending,
  output logic       err,
  output logic       buf_ne,
  output logic       arb_lost,
  output logic       incomplete,
  output logic       aborted,
  output logic       bus_busy,
  output logic       stop_done,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe
);
  localparam int DEPTH = 1 << CNT_W;
  localparam int QW    = $clog2(QTR_STD + 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_BYTE, S_STOP, S_RSTART, S_HOLD, S_RSHOLD} st_t;

  st_t              st;
  logic [1:0]       ph;
  logic [3:0]       bitn;
  logic [7:0]       sh;
  logic [CNT_W:0]   left;
  logic [QW-1:0]    qcnt;
  logic             addr_ph, scl_dr, sda_dr, scl_q, sda_q;
  logic             c_rd, c_chain, c_rpt;
  logic [6:0]       c_addr;
  logic [7:0]       mem [DEPTH];
  logic [CNT_W-1:0] wp, rp;
  logic [CNT_W:0]   cnt;

  wire [QW-1:0] qload   = fast_mode ? QW'(QTR_FAST - 1) : QW'(QTR_STD - 1);
  wire          waiting = (st == S_IDLE) || (st == S_HOLD) || (st == S_RSHOLD);
  wire          stall   = !scl_dr && !scl_i;
  wire          tick    = !waiting && !stall && (qcnt == '0);
  wire          wr_now  = addr_ph || !c_rd;
  wire          bit_end = tick && (st == S_BYTE) && (ph == 2'd3) && (bitn == 4'd8);
  wire          empty   = (cnt == '0);
  wire          load_now = (st == S_HOLD && pending && !c_rd) ||
                           (bit_end && !c_rd && !sda_i && (addr_ph || left > 1));
  wire          in_push = bit_end && !wr_now;
  wire          do_push = (in_push || wr_push) && (cnt != (CNT_W+1)'(DEPTH));
  wire          do_pop  = (load_now || rd_pop) && !empty;

  assign rd_data = mem[rp];
  assign buf_ne  = !empty;
  assign err     = arb_lost | incomplete | aborted;
  assign scl_oe  = scl_dr;
  assign sda_oe  = sda_dr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else if (flush) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (do_push) begin
        mem[wp] <= in_push ? sh : wr_data;
        wp <= wp + 1'b1;
      end
      if (do_pop) rp <= rp + 1'b1;
      cnt <= cnt + (CNT_W+1)'(do_push) - (CNT_W+1)'(do_pop);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= 1'b1; sda_q <= 1'b1; bus_busy <= 1'b0;
    end else begin
      scl_q <= scl_i; sda_q <= sda_i;
      if (scl_q && scl_i && sda_q && !sda_i) bus_busy <= 1'b1;
      else if (scl_q && scl_i && !sda_q && sda_i) bus_busy <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) qcnt <= '0;
    else if (waiting || tick) qcnt <= qload;
    else if (!stall) qcnt <= qcnt - 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; ph <= '0; bitn <= '0; sh <= '0; left <= '0; addr_ph <= 1'b0;
      scl_dr <= 1'b0; sda_dr <= 1'b0; pending <= 1'b0;
      c_rd <= 1'b0; c_chain <= 1'b0; c_rpt <= 1'b0; c_addr <= '0;
      arb_lost <= 1'b0; incomplete <= 1'b0; aborted <= 1'b0; stop_done <= 1'b0;
    end else begin
      if (cmd_wr && !pending) begin
        pending <= 1'b1;
        c_rd    <= cmd_ctrl[0];
        c_chain <= cmd_ctrl[1];
        c_rpt   <= cmd_ctrl[2];
        c_addr  <= dev_addr;
        left    <= {1'b0, cmd_ctrl[4 +: CNT_W]} + 1'b1;
      end
      if (tick) ph <= ph + 1'b1;
      case (st)
        S_IDLE: if (pending && !bus_busy) begin st <= S_START; ph <= '0; end
        S_HOLD: if (pending) begin
          st <= S_BYTE; ph <= '0; bitn <= '0; addr_ph <= 1'b0; sh <= 8'hFF;
          if (load_now) begin
            if (empty) begin aborted <= 1'b1; st <= S_STOP; end
            else sh <= mem[rp];
          end
        end
        S_RSHOLD: if (pending) begin
          st <= S_BYTE; ph <= '0; bitn <= '0; addr_ph <= 1'b1; sh <= {c_addr, c_rd};
        end
        S_START: if (tick) begin
          if (ph == 2'd0) sda_dr <= 1'b1;
          if (ph == 2'd3) begin
            scl_dr <= 1'b1; st <= S_BYTE; bitn <= '0; addr_ph <= 1'b1; sh <= {c_addr, c_rd};
          end
        end
        S_BYTE: if (tick) begin
          case (ph)
            2'd0: sda_dr <= (bitn < 4'd8) ? (wr_now && !sh[7]) : (!wr_now && (left > 1 || c_chain));
            2'd1: scl_dr <= 1'b0;
            2'd3: begin
              scl_dr <= 1'b1;
              if (bitn < 4'd8) begin
                if (wr_now && sh[7] && !sda_i) begin
                  arb_lost <= 1'b1; scl_dr <= 1'b0; sda_dr <= 1'b0;
                  st <= S_IDLE; pending <= 1'b0;
                end else begin
                  sh <= {sh[6:0], sda_i}; bitn <= bitn + 1'b1;
                end
              end else begin
                bitn <= '0;
                if (wr_now && sda_i) begin
                  incomplete <= 1'b1; st <= S_STOP;
                end else begin
                  if (!addr_ph) left <= left - 1'b1;
                  addr_ph <= 1'b0;
                  sh <= 8'hFF;
                  if (load_now) begin
                    if (empty) begin aborted <= 1'b1; st <= S_STOP; end
                    else sh <= mem[rp];
                  end else if (!addr_ph && left == 1) begin
                    if (c_chain) begin st <= S_HOLD; sda_dr <= 1'b0; pending <= 1'b0; end
                    else if (c_rpt) st <= S_RSTART;
                    else st <= S_STOP;
                  end
                end
              end
            end
            default: ;
          endcase
        end
        S_STOP: if (tick) begin
          case (ph)
            2'd0: sda_dr <= 1'b1;
            2'd1: scl_dr <= 1'b0;
            2'd2: sda_dr <= 1'b0;
            default: begin st <= S_IDLE; stop_done <= 1'b1; pending <= 1'b0; end
          endcase
        end
        S_RSTART: if (tick) begin
          case (ph)
            2'd0: sda_dr <= 1'b0;
            2'd1: scl_dr <= 1'b0;
            2'd2: sda_dr <= 1'b1;
            default: begin scl_dr <= 1'b1; st <= S_RSHOLD; pending <= 1'b0; end
          endcase
        end
        default: st <= S_IDLE;
      endcase
      if (clr_wr) begin
        if (clr_mask[0]) stop_done  <= 1'b0;
        if (clr_mask[1]) arb_lost   <= 1'b0;
        if (clr_mask[2]) incomplete <= 1'b0;
        if (clr_mask[3]) aborted    <= 1'b0;
      end
    end

  p_cmd_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending) |-> $past(cmd_wr));
  p_held_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HOLD) |-> scl_oe);
  p_rs_parked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RSHOLD) |-> (scl_oe && sda_oe));
  p_nack_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(incomplete) |-> (st == S_STOP));
  p_abort_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aborted) |-> (st == S_STOP));
  p_la_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arb_lost) |-> (!scl_oe && !sda_oe && !pending));
  p_buf_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= (CNT_W+1)'(DEPTH));
  p_sda_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BYTE && $past(st) == S_BYTE && $past(scl_i) && scl_i) |-> $stable(sda_oe));
endmodule

// File: tb/test_chunk_i2c_master.sv
module test_chunk_i2c_master;
  localparam int CLK_PERIOD = 10;
  localparam int QS = 20;
  localparam int QF = 5;
  localparam logic [6:0] SLV = 7'h50;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fast_mode = 1'b0, cmd_wr = 1'b0, wr_push = 1'b0, rd_pop = 1'b0, flush = 1'b0, clr_wr = 1'b0;
  logic [7:0] cmd_ctrl = '0, wr_data = '0;
  logic [6:0] dev_addr = SLV;
  logic [3:0] clr_mask = '0;
  logic [7:0] rd_data;
  logic pending, err, buf_ne, arb_lost, incomplete, aborted, bus_busy, stop_done, scl_oe, sda_oe;
  logic s_sda = 1'b0, rival = 1'b0;
  wire scl = !scl_oe;
  wire sda = !(sda_oe || s_sda || rival);

  chunk_i2c_master #(.QTR_STD(QS), .QTR_FAST(QF), .CNT_W(2)) i_chunk_i2c_master (
    .clk(clk), .rst_n(rst_n), .fast_mode(fast_mode), .cmd_wr(cmd_wr), .cmd_ctrl(cmd_ctrl),
    .dev_addr(dev_addr), .wr_push(wr_push), .wr_data(wr_data), .rd_pop(rd_pop), .rd_data(rd_data),
    .flush(flush), .clr_wr(clr_wr), .clr_mask(clr_mask), .pending(pending), .err(err),
    .buf_ne(buf_ne), .arb_lost(arb_lost), .incomplete(incomplete), .aborted(aborted),
    .bus_busy(bus_busy), .stop_done(stop_done), .scl_i(scl), .sda_i(sda),
    .scl_oe(scl_oe), .sda_oe(sda_oe));

  always #(CLK_PERIOD/2) clk = !clk;

  int compared = 0, mismatched = 0;
  int starts = 0, stops = 0, acks = 0, nacks = 0, hi_cnt = 0, last_hi = 0, r13_bad = 0;
  int nack_after = -1, mode = 0, bitc = 0;
  logic [7:0] got[$];
  logic [7:0] shr = '0, rb = '0, rd_ctr = 8'hA0;
  logic aok = 1'b0, rdm = 1'b0, mack = 1'b0, wnack = 1'b0, m_busy = 1'b0;
  logic scl_p = 1'b1, sda_p = 1'b1, oe_p = 1'b0;

  // behavioural target plus a bus-state model
  always @(posedge clk) begin
    if (!rst_n) begin
      mode = 0; bitc = 0; m_busy = 0; s_sda <= 1'b0;
    end else begin
      if (scl) hi_cnt++;
      else if (scl_p) begin last_hi = hi_cnt; hi_cnt = 0; end
      if (scl_p && scl && sda_oe != oe_p && sda == sda_p) r13_bad++;
      if (scl_p && scl && sda_p && !sda) begin
        starts++; m_busy = 1; mode = 1; bitc = 0;
      end else if (scl_p && scl && !sda_p && sda) begin
        stops++; m_busy = 0; mode = 0;
      end else if (!scl_p && scl && mode != 0) begin
        if (bitc < 8 && mode != 3) shr = {shr[6:0], sda};
        if (bitc == 8 && mode == 3) begin
          mack = !sda;
          if (!sda) acks++; else nacks++;
        end
        bitc++;
      end else if (scl_p && !scl && mode != 0) begin
        if (bitc == 8) begin
          if (mode == 1) begin aok = (shr[7:1] == SLV); rdm = shr[0]; s_sda <= aok; end
          else if (mode == 2) begin
            got.push_back(shr);
            wnack = (got.size() == nack_after);
            s_sda <= !wnack;
          end else s_sda <= 1'b0;
        end else if (bitc == 9) begin
          bitc = 0;
          if (mode == 1) begin
            if (!aok) begin mode = 0; s_sda <= 1'b0; end
            else if (rdm) begin mode = 3; rb = rd_ctr; rd_ctr++; s_sda <= !rb[7]; end
            else begin mode = 2; s_sda <= 1'b0; end
          end else if (mode == 2) begin
            s_sda <= 1'b0;
            if (wnack) mode = 0;
          end else begin
            if (mack) begin rb = rd_ctr; rd_ctr++; s_sda <= !rb[7]; end
            else begin mode = 0; s_sda <= 1'b0; end
          end
        end else if (mode == 3) s_sda <= !rb[7-bitc];
      end
      scl_p = scl; sda_p = sda; oe_p = sda_oe;
    end
  end

  // every-clock comparison of the bus state (R10)
  always @(negedge clk) if (rst_n) begin
    compared++;
    if (bus_busy !== m_busy) begin
      mismatched++;
      $display("FAIL R10 bus_busy act=%0d exp=%0d t=%0t", bus_busy, m_busy, $time);
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk); wr_push = 1'b1; wr_data = b;
    @(negedge clk); wr_push = 1'b0;
  endtask

  task automatic issue(input bit rd, input bit ch, input bit rs, input int n, input logic [6:0] a);
    @(negedge clk); cmd_wr = 1'b1; dev_addr = a;
    cmd_ctrl = {2'b00, 2'(n - 1), 1'b0, rs, ch, rd};
    @(negedge clk); cmd_wr = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    @(negedge clk);
    while (pending && n < 40000) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic clear(input logic [3:0] m);
    @(negedge clk); clr_wr = 1'b1; clr_mask = m;
    @(negedge clk); clr_wr = 1'b0; clr_mask = '0;
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
  endtask

  task automatic pop_chk(input logic [7:0] exp, input string tag);
    @(negedge clk); chk(rd_data == exp, tag, rd_data, exp); rd_pop = 1'b1;
    @(negedge clk); rd_pop = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int s0, p0, a0, n0;
    logic [7:0] e0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state (R2)
    chk(!pending && !err && !bus_busy && !scl_oe && !sda_oe && !buf_ne, "R2 reset", pending, 0);

    // plain write of three bytes (R1, R10)
    push(8'hAA); push(8'h55); push(8'hC3);
    s0 = starts; p0 = stops;
    issue(0, 0, 0, 3, SLV);
    wait_done();
    chk(got.size() == 3, "R1 write count", got.size(), 3);
    chk(got.size() == 3 && got[0] == 8'hAA && got[1] == 8'h55 && got[2] == 8'hC3, "R1 write data",
        got.size() > 2 ? got[2] : 0, 8'hC3);
    chk(stop_done && starts == s0 + 1 && stops == p0 + 1, "R10 stop", stops - p0, 1);
    chk(!err && !bus_busy, "R10 bus free", bus_busy, 0);
    chk(last_hi >= 2*QS - 1 && last_hi <= 2*QS + 1, "R11 std high", last_hi, 2*QS);
    clear(4'b0001);
    chk(!stop_done, "R9 clear stop_done", stop_done, 0);

    // count field smaller than buffer content, command ignored while pending (R1, R2, R12)
    got.delete();
    push(8'h11); push(8'h22); push(8'h33); push(8'h44);
    s0 = starts;
    issue(0, 0, 0, 2, SLV);
    repeat (30) @(negedge clk);
    chk(pending, "R2 pending set", pending, 1);
    issue(0, 0, 0, 4, SLV);
    wait_done();
    repeat (200) @(negedge clk);
    chk(got.size() == 2 && got[1] == 8'h22, "R1 count two", got.size(), 2);
    chk(!pending && starts == s0 + 1, "R2 second command ignored", starts - s0, 1);
    chk(buf_ne, "R1 leftover bytes", buf_ne, 1);
    do_flush();
    chk(!buf_ne, "R12 flush", buf_ne, 0);

    // read of four bytes (R5)
    a0 = acks; n0 = nacks; e0 = rd_ctr;
    issue(1, 0, 0, 4, SLV);
    wait_done();
    chk(buf_ne, "R5 buf_ne", buf_ne, 1);
    chk(acks == a0 + 3 && nacks == n0 + 1, "R5 ack pattern", acks - a0, 3);
    for (int i = 0; i < 4; i++) pop_chk(e0 + 8'(i), "R5 read data");
    chk(!buf_ne, "R5 drained", buf_ne, 0);

    // chained write (R3)
    got.delete();
    s0 = starts; p0 = stops;
    push(8'h01); push(8'h02);
    issue(0, 1, 0, 2, SLV);
    wait_done();
    chk(!pending && scl_oe && stops == p0 && bus_busy, "R3 held", scl_oe, 1);
    push(8'h03); push(8'h04);
    issue(0, 0, 0, 2, SLV);
    wait_done();
    chk(got.size() == 4 && got[2] == 8'h03 && got[3] == 8'h04, "R3 continued", got.size(), 4);
    chk(starts == s0 + 1 && stops == p0 + 1, "R3 single start", starts - s0, 1);

    // write then repeated start read (R4)
    got.delete();
    s0 = starts; p0 = stops; e0 = rd_ctr;
    push(8'h07);
    issue(0, 0, 1, 1, SLV);
    wait_done();
    chk(!pending && scl_oe && sda_oe && stops == p0, "R4 parked after Sr", stops - p0, 0);
    issue(1, 0, 0, 2, SLV);
    wait_done();
    chk(starts == s0 + 2 && stops == p0 + 1 && got.size() == 1 && got[0] == 8'h07,
        "R4 start count", starts - s0, 2);
    pop_chk(e0, "R4 data0");
    pop_chk(e0 + 8'd1, "R4 data1");

    // address not acknowledged (R6, R9)
    p0 = stops;
    issue(1, 0, 0, 1, 7'h33);
    wait_done();
    chk(incomplete && err && stops == p0 + 1 && !bus_busy, "R6 address nack", incomplete, 1);
    clear(4'b0100);
    chk(!incomplete && !err, "R9 clear incomplete", err, 0);

    // data byte not acknowledged (R6)
    got.delete(); nack_after = 2;
    push(8'hD0); push(8'hD1); push(8'hD2);
    issue(0, 0, 0, 3, SLV);
    wait_done();
    chk(incomplete && err && got.size() == 2, "R6 data nack", got.size(), 2);
    nack_after = -1;
    clear(4'b0100);
    do_flush();

    // write with empty buffer (R7)
    p0 = stops;
    issue(0, 0, 0, 1, SLV);
    wait_done();
    chk(aborted && err && stops == p0 + 1 && !bus_busy, "R7 abort", aborted, 1);
    clear(4'b1000);
    chk(!aborted && !err, "R9 clear aborted", aborted, 0);

    // fast timing (R11)
    fast_mode = 1'b1;
    push(8'h5A);
    issue(0, 0, 0, 1, SLV);
    wait_done();
    chk(last_hi >= 2*QF - 1 && last_hi <= 2*QF + 1, "R11 fast high", last_hi, 2*QF);
    fast_mode = 1'b0;

    // arbitration lost (R8)
    push(8'h5A);
    issue(0, 0, 0, 1, SLV);
    while (!bus_busy) @(negedge clk);
    rival = 1'b1;
    for (int k = 0; k < 400 && !arb_lost; k++) @(negedge clk);
    @(negedge clk);
    chk(arb_lost && err && !pending && !scl_oe && !sda_oe, "R8 lost", arb_lost, 1);
    chk(bus_busy, "R8 bus still owned", bus_busy, 1);
    rival = 1'b0;
    repeat (3) @(negedge clk);
    chk(!bus_busy, "R10 free after rival stop", bus_busy, 0);
    clear(4'b0010);
    chk(r13_bad == 0, "R13 sda change while scl high", r13_bad, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule